// File: doc/BRIEF.md
# Parallel Flash Command-State Controller

This block models, in synthesizable form, the control state machine of a byte-wide parallel NOR flash. It watches the active-low chip-select, output-enable, write-enable and hardware-reset strobes, takes an address and a data byte, and decides whether each bus cycle is a read, a command write or nothing at all. It tracks read-array, identifier, busy (program or erase), erase-suspended and reset-recovery modes. It drives a ready/busy line, the polling (bit 7) and toggle (bit 6) status bits, and an enable for an external tri-state data driver.

A small banked register array stands in for the cell array. Its sectors are selected by the upper address bits. Program and erase durations, and the recovery time after a reset that interrupts an operation, come from parameterised cycle counters. Each command is a single write, and the opcode is carried on the data bus: A0h arms a program, 30h erases the addressed sector (and resumes a suspended erase), 10h erases every sector, B0h suspends an erase in progress, 90h enters identifier mode, and F0h leaves it.

All pins are sampled on the rising clock edge. A command is taken on the first clock edge of each write-enable low pulse.

Top module: `flash_cmd_ctl`

## Requirements
- R1: After power-up reset, and after any hardware-reset pulse, the block is in read-array mode. A read then returns stored data with no command issued, and an erased device reads FFh.
- R2: A command is accepted only when ce_ni=0, we_ni=0 and oe_ni=1, and at most one command is taken per write-enable low pulse. A write strobe with oe_ni=0 or ce_ni=1 changes nothing.
- R3: data_oe_o is 1 exactly while ce_ni=0, oe_ni=0, we_ni=1 and reset_ni=1. When data_oe_o is 0, data_o reads 00h.
- R4: While reset_ni=0, data_oe_o is 0 and writes are ignored. An interrupted program leaves its byte unchanged.
- R5: If reset_ni is low on a clock edge while a program or erase runs, ry_by_o stays 0 for exactly READY_CYC cycles counted from that edge. A reset pulse while idle keeps ry_by_o at 1.
- R6: A0h followed by a data write to an address starts a program. ry_by_o is 0 for exactly PGM_CYC cycles, and the stored byte then equals the old value ANDed with the new value.
- R7: 30h erases the sector selected by the top SECT_BITS address bits, and 10h erases all sectors. ry_by_o is 0 for exactly ERS_CYC cycles, after which every byte of the target reads FFh while other sectors keep their data.
- R8: While busy, a read returns bit 7 equal to the complement of bit 7 of the data being written (0 during erase), bit 6 inverted on each successive read, and bits 5:0 equal to 0.
- R9: B0h during an erase makes ry_by_o 1 on the next cycle. In this suspended state, sectors outside the erase can be read and programmed (busy PGM_CYC cycles, then suspended again). A program aimed at an erasing sector is ignored.
- R10: 30h in the suspended state resumes the erase with its remaining count rather than a fresh one. On completion the erased sector reads FFh.
- R11: Raising ce_ni during a program or erase does not stop it or change its duration.
- R12: After 90h, reads at even addresses return MFR_CODE and reads at odd addresses return DEV_CODE, until F0h restores read-array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous power-up reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| reset_ni | input | 1 | Hardware reset pin, active low, sampled |
| addr_i | input | ADDR_W | Byte address, upper SECT_BITS select sector |
| data_i | input | 8 | Command or program data |
| data_o | output | 8 | Read data or status |
| data_oe_o | output | 1 | Enable for the external data driver |
| ry_by_o | output | 1 | 1 = ready, 0 = busy |

## Verification
Reads are combinational from the pins and the current mode, so the bench samples read data and data_oe_o half a period after it drives the strobes. The toggle bit flips on the following edge. Commands take effect on the edge inside the write pulse: a program or erase drives ry_by_o low from the falling edge after that edge for exactly PGM_CYC or ERS_CYC samples, and a busy reset for READY_CYC samples from the first edge that sees reset_ni low. The bench counts busy samples at falling edges and compares them with these figures, including the remaining erase count after a suspend of known length (ERS_CYC minus 5).

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  typedef enum logic [3:0] {
    M_READ,
    M_IDENT,
    M_PGM_ARM,
    M_PGM_RUN,
    M_ERS_RUN,
    M_SUSP,
    M_SUSP_ARM,
    M_SUSP_PGM,
    M_RST_HOLD
  } mode_e;

  localparam logic [7:0] OP_PGM      = 8'hA0;
  localparam logic [7:0] OP_SECT_ERS = 8'h30;
  localparam logic [7:0] OP_CHIP_ERS = 8'h10;
  localparam logic [7:0] OP_SUSP     = 8'hB0;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_EXIT     = 8'hF0;

  function automatic logic is_status(mode_e m);
    return (m == M_PGM_RUN) || (m == M_ERS_RUN) || (m == M_SUSP_PGM) || (m == M_RST_HOLD);
  endfunction

  // operations a hardware reset must abort with a recovery delay
  function automatic logic is_op(mode_e m);
    return (m == M_PGM_RUN) || (m == M_ERS_RUN) || (m == M_SUSP) ||
           (m == M_SUSP_ARM) || (m == M_SUSP_PGM);
  endfunction

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic reset_ni,
  output logic rd_en_o,
  output logic rd_stb_o,
  output logic wr_stb_o
);

  logic rd_cond, wr_cond, rd_q, wr_q;

  assign rd_cond = reset_ni & ~ce_ni & ~oe_ni & we_ni;
  assign wr_cond = reset_ni & ~ce_ni & ~we_ni & oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_cond;
      wr_q <= wr_cond;
    end
  end

  assign rd_en_o  = rd_cond;
  assign rd_stb_o = rd_cond & ~rd_q;
  assign wr_stb_o = wr_cond & ~wr_q;

  // R2
  one_cmd_per_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         run_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= val_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R6 R7: an expired count stays expired until reloaded
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int unsigned SECT_BITS = 2,
  parameter int unsigned OFS_BITS  = 3,
  localparam int unsigned ADDR_W   = SECT_BITS + OFS_BITS,
  localparam int unsigned SECTORS  = 1 << SECT_BITS,
  localparam int unsigned SECT_BYTES = 1 << OFS_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [7:0]         rd_data_o,
  input  logic               pgm_en_i,
  input  logic [ADDR_W-1:0]  pgm_addr_i,
  input  logic [7:0]         pgm_data_i,
  input  logic               ers_en_i,
  input  logic [SECTORS-1:0] ers_mask_i
);

  logic [SECTORS-1:0][7:0] sect_rd;
  logic [OFS_BITS-1:0] rd_ofs, pgm_ofs;

  assign rd_ofs  = rd_addr_i[OFS_BITS-1:0];
  assign pgm_ofs = pgm_addr_i[OFS_BITS-1:0];

  for (genvar s = 0; s < SECTORS; s++) begin : g_sect
    logic [7:0] bank_q [SECT_BYTES];
    logic hit;

    assign hit = pgm_en_i && (pgm_addr_i[ADDR_W-1:OFS_BITS] == SECT_BITS'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < SECT_BYTES; i++) bank_q[i] <= 8'hFF;
      end else if (ers_en_i && ers_mask_i[s]) begin
        for (int i = 0; i < SECT_BYTES; i++) bank_q[i] <= 8'hFF;
      end else if (hit) begin
        bank_q[pgm_ofs] <= bank_q[pgm_ofs] & pgm_data_i;
      end
    end

    assign sect_rd[s] = bank_q[rd_ofs];

    // R6: programming never sets a bit
    pgm_clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && !ers_en_i) |=> ((bank_q[$past(pgm_ofs)] & ~$past(bank_q[pgm_ofs])) == 8'h00));
  end

  assign rd_data_o = sect_rd[rd_addr_i[ADDR_W-1:OFS_BITS]];

endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_ctl_pkg::*;
#(
  parameter int unsigned SECT_BITS = 2,
  parameter int unsigned OFS_BITS  = 3,
  parameter int unsigned PGM_CYC   = 6,
  parameter int unsigned ERS_CYC   = 20,
  parameter int unsigned READY_CYC = 5,
  parameter logic [7:0]  MFR_CODE  = 8'hC3,
  parameter logic [7:0]  DEV_CODE  = 8'h5A,
  localparam int unsigned ADDR_W   = SECT_BITS + OFS_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              reset_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              ry_by_o
);

  localparam int unsigned SECTORS = 1 << SECT_BITS;
  localparam int unsigned MAX_A   = (PGM_CYC > READY_CYC) ? PGM_CYC : READY_CYC;
  localparam int unsigned MAX_C   = (MAX_A > ERS_CYC) ? MAX_A : ERS_CYC;
  localparam int unsigned TMR_W   = $clog2(MAX_C + 1);

  mode_e mode_q, mode_d;
  logic [ADDR_W-1:0]  pgm_addr_q, pgm_addr_d;
  logic [7:0]         pgm_data_q, pgm_data_d;
  logic [SECTORS-1:0] ers_mask_q, ers_mask_d, sect_onehot;
  logic               tgl_q;

  logic rd_en, rd_stb, wr_stb;
  logic op_load, op_zero, ers_load, ers_zero, pgm_en, ers_en;
  logic [TMR_W-1:0] op_val;
  logic [7:0] arr_rd;
  logic status_mode;

  flash_bus_decode u_dec (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .reset_ni,
    .rd_en_o(rd_en), .rd_stb_o(rd_stb), .wr_stb_o(wr_stb)
  );

  flash_busy_timer #(.W(TMR_W)) u_op_tmr (
    .clk_i, .rst_ni, .load_i(op_load), .val_i(op_val),
    .run_i(mode_q == M_PGM_RUN || mode_q == M_SUSP_PGM || mode_q == M_RST_HOLD),
    .zero_o(op_zero)
  );

  flash_busy_timer #(.W(TMR_W)) u_ers_tmr (
    .clk_i, .rst_ni, .load_i(ers_load), .val_i(TMR_W'(ERS_CYC - 1)),
    .run_i(mode_q == M_ERS_RUN), .zero_o(ers_zero)
  );

  flash_cell_array #(.SECT_BITS(SECT_BITS), .OFS_BITS(OFS_BITS)) u_arr (
    .clk_i, .rst_ni, .rd_addr_i(addr_i), .rd_data_o(arr_rd),
    .pgm_en_i(pgm_en), .pgm_addr_i(pgm_addr_q), .pgm_data_i(pgm_data_q),
    .ers_en_i(ers_en), .ers_mask_i(ers_mask_q)
  );

  assign sect_onehot = SECTORS'(1) << addr_i[ADDR_W-1:OFS_BITS];

  always_comb begin
    mode_d     = mode_q;
    pgm_addr_d = pgm_addr_q;
    pgm_data_d = pgm_data_q;
    ers_mask_d = ers_mask_q;
    op_load    = 1'b0;
    op_val     = TMR_W'(PGM_CYC - 1);
    ers_load   = 1'b0;
    pgm_en     = 1'b0;
    ers_en     = 1'b0;
    if (!reset_ni) begin
      ers_mask_d = '0;
      if (is_op(mode_q)) begin
        mode_d  = M_RST_HOLD;
        op_load = 1'b1;
        op_val  = TMR_W'(READY_CYC - 1);
      end else if (mode_q != M_RST_HOLD || op_zero) begin
        mode_d = M_READ;
      end
    end else begin
      unique case (mode_q)
        M_READ: if (wr_stb) begin
          unique case (data_i)
            OP_PGM:      mode_d = M_PGM_ARM;
            OP_IDENT:    mode_d = M_IDENT;
            OP_SECT_ERS: begin mode_d = M_ERS_RUN; ers_mask_d = sect_onehot; ers_load = 1'b1; end
            OP_CHIP_ERS: begin mode_d = M_ERS_RUN; ers_mask_d = '1;          ers_load = 1'b1; end
            default: ;
          endcase
        end
        M_IDENT: if (wr_stb && data_i == OP_EXIT) mode_d = M_READ;
        M_PGM_ARM: if (wr_stb) begin
          pgm_addr_d = addr_i;
          pgm_data_d = data_i;
          op_load    = 1'b1;
          mode_d     = M_PGM_RUN;
        end
        M_PGM_RUN: if (op_zero) begin pgm_en = 1'b1; mode_d = M_READ; end
        M_ERS_RUN: begin
          if (ers_zero) begin
            ers_en = 1'b1; ers_mask_d = '0; mode_d = M_READ;
          end else if (wr_stb && data_i == OP_SUSP) begin
            mode_d = M_SUSP;
          end
        end
        M_SUSP: if (wr_stb) begin
          if (data_i == OP_PGM)           mode_d = M_SUSP_ARM;
          else if (data_i == OP_SECT_ERS) mode_d = M_ERS_RUN;
        end
        M_SUSP_ARM: if (wr_stb) begin
          if ((ers_mask_q & sect_onehot) != '0) begin
            mode_d = M_SUSP;
          end else begin
            pgm_addr_d = addr_i;
            pgm_data_d = data_i;
            op_load    = 1'b1;
            mode_d     = M_SUSP_PGM;
          end
        end
        M_SUSP_PGM: if (op_zero) begin pgm_en = 1'b1; mode_d = M_SUSP; end
        M_RST_HOLD: if (op_zero) mode_d = M_READ;
        default: mode_d = M_READ;
      endcase
    end
  end

  assign status_mode = is_status(mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= M_READ;
      pgm_addr_q <= '0;
      pgm_data_q <= 8'hFF;
      ers_mask_q <= '0;
      tgl_q      <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      pgm_addr_q <= pgm_addr_d;
      pgm_data_q <= pgm_data_d;
      ers_mask_q <= ers_mask_d;
      if (rd_stb && status_mode) tgl_q <= ~tgl_q;
    end
  end

  logic poll_b7;
  assign poll_b7 = (mode_q == M_PGM_RUN || mode_q == M_SUSP_PGM) ? pgm_data_q[7] : 1'b1;

  always_comb begin
    if (!rd_en)                data_o = 8'h00;
    else if (status_mode)      data_o = {~poll_b7, tgl_q, 6'b0};
    else if (mode_q == M_IDENT) data_o = addr_i[0] ? DEV_CODE : MFR_CODE;
    else                       data_o = arr_rd;
  end

  assign data_oe_o = rd_en;
  assign ry_by_o   = !status_mode;

  // R4
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reset_ni |-> !data_oe_o);

  // R5
  reset_keeps_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reset_ni && (mode_q == M_PGM_RUN || mode_q == M_ERS_RUN || mode_q == M_SUSP_PGM)) |=> !ry_by_o);

  // R11
  pgm_runs_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_PGM_RUN && reset_ni && !op_zero) |=> (mode_q == M_PGM_RUN && !ry_by_o));

  // R8
  toggle_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb && status_mode) |=> (tgl_q != $past(tgl_q)));

  // R9
  suspend_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_ERS_RUN && reset_ni && !ers_zero && wr_stb && data_i == OP_SUSP) |=> ry_by_o);

endmodule

// File: tb/flash_cmd_ctl_test.sv
module flash_cmd_ctl_test;

  localparam int PGM_CYC = 6, ERS_CYC = 20, READY_CYC = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, res_n = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic doe, ry;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  flash_cmd_ctl #(.SECT_BITS(2), .OFS_BITS(3), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC),
                  .READY_CYC(READY_CYC), .MFR_CODE(8'hC3), .DEV_CODE(8'h5A)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .reset_ni(res_n), .addr_i(addr), .data_i(din), .data_o(dout),
    .data_oe_o(doe), .ry_by_o(ry)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #5;
    d = dout; oe = doe;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (ry !== 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    logic [7:0] d; logic oe;
    chk("R1 ready after reset", ry, 1);
    rd(5'd0, d, oe);
    chk("R1 erased read", d, 8'hFF);
    chk("R3 read drives", oe, 1);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    #5;
    chk("R3 oe high no drive", doe, 0);
    chk("R3 idle data", dout, 8'h00);
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic t_program();
    logic [7:0] d; logic oe; int n;
    wr(5'd0, 8'hA0); wr(5'd9, 8'h3C);
    busy_len(n);
    chk("R6 program busy length", n, PGM_CYC);
    rd(5'd9, d, oe);
    chk("R6 program value", d, 8'h3C);
    wr(5'd0, 8'hA0); wr(5'd9, 8'hF0);
    busy_len(n);
    rd(5'd9, d, oe);
    chk("R6 program ands", d, 8'h30);
  endtask

  task automatic t_status();
    logic [7:0] d1, d2, d; logic oe; int n;
    wr(5'd0, 8'hA0); wr(5'd2, 8'h80);
    rd(5'd2, d1, oe);
    rd(5'd2, d2, oe);
    chk("R8 poll bit complement", d1[7], 0);
    chk("R8 toggle flips", d1[6] ^ d2[6], 1);
    chk("R8 low bits zero", d1[5:0], 0);
    busy_len(n);
    rd(5'd2, d, oe);
    chk("R8 data after done", d, 8'h80);
  endtask

  task automatic t_inhibit();
    logic [7:0] d; logic oe;
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 5'd3; din = 8'hA0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    wr(5'd3, 8'h00);
    chk("R2 oe low inhibits", ry, 1);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1; din = 8'hA0;
    @(negedge clk);
    we_n = 1'b1;
    wr(5'd3, 8'h00);
    chk("R2 ce high inhibits", ry, 1);
    rd(5'd3, d, oe);
    chk("R2 byte untouched", d, 8'hFF);
  endtask

  task automatic t_ce_high();
    logic [7:0] d; logic oe; int n;
    wr(5'd0, 8'hA0); wr(5'd4, 8'h0F);
    busy_len(n);
    chk("R11 busy with ce high", n, PGM_CYC);
    rd(5'd4, d, oe);
    chk("R11 program completed", d, 8'h0F);
  endtask

  task automatic t_erase();
    logic [7:0] d; logic oe; int n;
    wr(5'd8, 8'h30);
    busy_len(n);
    chk("R7 sector erase length", n, ERS_CYC);
    rd(5'd9, d, oe);
    chk("R7 sector erased", d, 8'hFF);
    rd(5'd2, d, oe);
    chk("R7 other sector kept", d, 8'h80);
    wr(5'd0, 8'h10);
    rd(5'd0, d, oe);
    chk("R8 erase poll bit", d[7], 0);
    busy_len(n);
    rd(5'd2, d, oe);
    chk("R7 chip erase", d, 8'hFF);
    rd(5'd4, d, oe);
    chk("R7 chip erase 2", d, 8'hFF);
  endtask

  task automatic t_suspend();
    logic [7:0] d; logic oe; int n;
    wr(5'd0, 8'hA0); wr(5'd17, 8'h55); busy_len(n);
    wr(5'd0, 8'hA0); wr(5'd25, 8'hAA); busy_len(n);
    wr(5'd16, 8'h30);
    repeat (3) @(negedge clk);
    wr(5'd16, 8'hB0);
    chk("R9 ready when suspended", ry, 1);
    rd(5'd25, d, oe);
    chk("R9 read other sector", d, 8'hAA);
    wr(5'd0, 8'hA0); wr(5'd26, 8'h11);
    busy_len(n);
    chk("R9 suspended program length", n, PGM_CYC);
    rd(5'd26, d, oe);
    chk("R9 suspended program value", d, 8'h11);
    wr(5'd0, 8'hA0); wr(5'd18, 8'h00);
    chk("R9 erasing sector refused", ry, 1);
    rd(5'd18, d, oe);
    chk("R9 erasing sector untouched", d, 8'hFF);
    rd(5'd17, d, oe);
    chk("R9 erase held", d, 8'h55);
    wr(5'd16, 8'h30);
    chk("R10 resume busy", ry, 0);
    busy_len(n);
    chk("R10 remaining count", n, ERS_CYC - 5);
    rd(5'd17, d, oe);
    chk("R10 erase finished", d, 8'hFF);
    rd(5'd25, d, oe);
    chk("R10 other sector kept", d, 8'hAA);
  endtask

  task automatic t_reset_busy();
    logic [7:0] d; logic oe; int n, lows;
    wr(5'd0, 8'hA0); wr(5'd5, 8'h00);
    @(negedge clk);
    res_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 5'd5;
    #5;
    chk("R4 no drive in reset", doe, 0);
    @(negedge clk);
    res_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    busy_len(n);
    chk("R5 reset recovery length", n, READY_CYC);
    rd(5'd5, d, oe);
    chk("R4 aborted program", d, 8'hFF);
    lows = 0;
    res_n = 1'b0;
    wr(5'd6, 8'hA0);
    if (ry !== 1'b1) lows++;
    res_n = 1'b1;
    @(negedge clk);
    if (ry !== 1'b1) lows++;
    chk("R5 idle reset stays ready", lows, 0);
    wr(5'd6, 8'h00);
    rd(5'd6, d, oe);
    chk("R4 write in reset ignored", d, 8'hFF);
  endtask

  task automatic t_ident();
    logic [7:0] d; logic oe;
    wr(5'd0, 8'h90);
    rd(5'd0, d, oe);
    chk("R12 maker code", d, 8'hC3);
    rd(5'd1, d, oe);
    chk("R12 device code", d, 8'h5A);
    wr(5'd0, 8'hF0);
    rd(5'd0, d, oe);
    chk("R12 exit to array", d, 8'hFF);
    wr(5'd0, 8'h90);
    @(negedge clk); res_n = 1'b0;
    @(negedge clk); res_n = 1'b1;
    rd(5'd1, d, oe);
    chk("R1 reset back to array", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_program();
    t_status();
    t_inhibit();
    t_ce_high();
    t_erase();
    t_suspend();
    t_reset_busy();
    t_ident();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule